// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Sequencer

This block sits between a synchronous host and an asynchronous 128K-word by 16-bit static RAM. Each host request carries a word address, write data, a two-bit byte mask and a read/write flag. The block turns the request into enable, strobe and data-bus activity whose durations are whole numbers of system clock cycles. Each duration is derived from a nanosecond timing figure and a clock-period parameter, and is rounded up. When the access is over, the block returns a one-cycle completion pulse. For a read, the captured data comes back with that pulse.

The RAM has separate active-low enables for the upper byte (bits 15:8) and the lower byte (bits 7:0). It also has an active-low write strobe and an active-low output enable. Mask bit 1 selects the upper lane and mask bit 0 selects the lower lane. The data bus is split into an output value, a per-lane drive enable and an input value, so that the pad ring can build the tristate. The controller accepts a request only while it is idle.

The state machine has six states. S_IDLE waits for a request. From S_IDLE, a zero mask goes to S_DONE (reject), a write goes to S_WR_PULSE, and a read goes to S_RD_SETUP. S_WR_PULSE holds the strobe low until the pulse timer expires, then goes to S_WR_HOLD. S_WR_HOLD keeps the strobe high with the data still driven until the recovery timer expires, then goes to S_DONE. S_RD_SETUP enables the lanes with the bus released and the output enable high, and lasts one cycle before going to S_RD_WAIT. S_RD_WAIT holds the output enable low until the access timer expires, samples the data, then goes to S_DONE. S_DONE pulses completion and always returns to S_IDLE.

Top module: `sram_bytelane_ctrl`

## Requirements
- R1: After reset, both byte enables, the write strobe and the output enable are high, no lane is driven, and done and done_err are low.
- R2: With the default timing (10 ns clock), a write holds mem_we_n low for exactly 6 cycles. A read holds mem_oe_n low for exactly 6 cycles. In both cases done is high for exactly one cycle, starting 7 clock edges after the accepting edge.
- R3: Mask bit 1 selects the upper lane: mem_ceu_n is low and bits 15:8 are used. Mask bit 0 selects the lower lane: mem_cel_n is low and bits 7:0 are used. Unselected lanes have their enable high and are neither driven nor sampled.
- R4: During a write, mem_dq_oe equals the mask and mem_dq_out carries the latched write data. Driving lasts from the first strobe-low cycle through the first cycle after the strobe rises. At all other times mem_dq_oe is 00.
- R5: mem_addr holds the latched request address for the whole access, even if the host inputs change after acceptance.
- R6: A read spends one cycle with the lanes enabled and mem_oe_n high, then drives mem_oe_n low. It samples mem_dq_in on the last low cycle. rd_data carries the selected lanes and zero in unselected lanes, and is valid while done is high.
- R7: The write strobe and the output enable are never low together. mem_oe_n never falls in a cycle that follows a cycle in which a lane was driven.
- R8: The write strobe stays low for at least 6 cycles. Successive falling edges of the strobe are at least 7 cycles apart. The strobe and both enables rise together when the write ends.
- R9: A request with mask 00 causes no RAM activity. done and done_err go high for one cycle, starting on the edge after the request.
- R10: A request strobe that arrives while an access is in progress is ignored: it changes neither the address nor the lane enables, and it produces no extra completion.
- R11: done_err stays low on every completion of an accepted read or write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Byte mask, bit 1 = upper lane, bit 0 = lower lane |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | High with done when a request was rejected |
| rd_data | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 17 | RAM address |
| mem_ceu_n | output | 1 | Upper byte enable, active low |
| mem_cel_n | output | 1 | Lower byte enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 16 | Data bus value driven by the controller |
| mem_dq_oe | output | 2 | Per-lane drive enable, bit 1 = upper lane |
| mem_dq_in | input | 16 | Data bus value returned by the RAM |

## Verification
Writes and reads are tried with the full mask, the upper-only mask and the lower-only mask. Because the two lanes are written with different values and read back through other masks, a swapped or merged lane shows up as wrong bytes. The RAM model returns a fixed pattern whenever its output enable is high, so reads that sample too early or at the wrong moment do not return stored data. Addresses at both ends of the range, host inputs scrambled after acceptance, a request injected mid-write and a zero mask separate correct latching from a design that follows the live inputs or restarts. A write followed at once by a read exposes a missing bus turnaround.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WR_PULSE,
        S_WR_HOLD,
        S_RD_SETUP,
        S_RD_WAIT,
        S_DONE
    } seq_state_e;

    localparam int LANE_COUNT = 2;

    // Convert a duration to whole clock cycles, rounding up.
    function automatic int ns_to_cyc(input int dur_ns, input int clk_ns);
        return (dur_ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_path.sv
module sram_lane_path #(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch,
    input  logic [LANE_W-1:0] wdata_in,
    input  logic              capture,
    input  logic              lane_sel,
    input  logic [LANE_W-1:0] dq_in,
    output logic [LANE_W-1:0] dq_out,
    output logic [LANE_W-1:0] rd_lane
);

    logic [LANE_W-1:0] wdata_q;
    logic [LANE_W-1:0] rdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdata_q <= '0;
        end else if (latch) begin
            wdata_q <= wdata_in;
        end
    end

    // An unselected lane reads back as zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= lane_sel ? dq_in : '0;
        end
    end

    assign dq_out  = wdata_q;
    assign rd_lane = rdata_q;

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int CNT_W    = 3,
    parameter int WP_CYC   = 6,
    parameter int HOLD_CYC = 1,
    parameter int RDW_CYC  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [1:0]       req_bmask,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             capture,
    output logic [1:0]       lane_sel,
    output logic             ceu_n,
    output logic             cel_n,
    output logic             we_n,
    output logic             oe_n,
    output logic [1:0]       lane_drive,
    output logic             done,
    output logic             err
);

    localparam logic [CNT_W-1:0] WP_LD   = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] RDW_LD  = CNT_W'(RDW_CYC - 1);

    seq_state_e state_q, state_d;
    logic [1:0] mask_q;
    logic [1:0] sel_mask;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions and timer control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    if (req_bmask == 2'b00) begin
                        state_d = S_DONE;
                    end else begin
                        accept = 1'b1;
                        if (req_write) begin
                            state_d  = S_WR_PULSE;
                            tmr_load = 1'b1;
                            tmr_val  = WP_LD;
                        end else begin
                            state_d = S_RD_SETUP;
                        end
                    end
                end
            end
            S_WR_PULSE: begin
                if (tmr_expired) begin
                    state_d  = S_WR_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = HOLD_LD;
                end
            end
            S_WR_HOLD: begin
                if (tmr_expired) begin
                    state_d = S_DONE;
                end
            end
            S_RD_SETUP: begin
                state_d  = S_RD_WAIT;
                tmr_load = 1'b1;
                tmr_val  = RDW_LD;
            end
            S_RD_WAIT: begin
                if (tmr_expired) begin
                    state_d = S_DONE;
                    capture = 1'b1;
                end
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    assign sel_mask = accept ? req_bmask : mask_q;
    assign lane_sel = mask_q;

    // Registered outputs decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q     <= 2'b00;
            ceu_n      <= 1'b1;
            cel_n      <= 1'b1;
            we_n       <= 1'b1;
            oe_n       <= 1'b1;
            lane_drive <= 2'b00;
            done       <= 1'b0;
            err        <= 1'b0;
        end else begin
            mask_q     <= sel_mask;
            ceu_n      <= 1'b1;
            cel_n      <= 1'b1;
            we_n       <= 1'b1;
            oe_n       <= 1'b1;
            lane_drive <= 2'b00;
            done       <= 1'b0;
            err        <= 1'b0;
            unique case (state_d)
                S_IDLE: begin
                end
                S_WR_PULSE: begin
                    ceu_n      <= ~sel_mask[1];
                    cel_n      <= ~sel_mask[0];
                    we_n       <= 1'b0;
                    lane_drive <= sel_mask;
                end
                S_WR_HOLD: begin
                    lane_drive <= sel_mask;
                end
                S_RD_SETUP: begin
                    ceu_n <= ~sel_mask[1];
                    cel_n <= ~sel_mask[0];
                end
                S_RD_WAIT: begin
                    ceu_n <= ~sel_mask[1];
                    cel_n <= ~sel_mask[0];
                    oe_n  <= 1'b0;
                end
                S_DONE: begin
                    done <= 1'b1;
                    err  <= (state_q == S_IDLE);
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/sram_bytelane_ctrl.sv
module sram_bytelane_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int LANE_W   = 8,
    parameter int CLK_NS   = 10,
    parameter int T_WP_NS  = 55,
    parameter int T_WC_NS  = 70,
    parameter int T_WR_NS  = 5,
    parameter int T_DS_NS  = 30,
    parameter int T_RC_NS  = 70,
    parameter int T_ACC_NS = 70,
    parameter int T_OE_NS  = 35
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [2*LANE_W-1:0]        req_wdata,
    input  logic [1:0]                 req_bmask,
    output logic                       done,
    output logic                       done_err,
    output logic [2*LANE_W-1:0]        rd_data,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic                       mem_ceu_n,
    output logic                       mem_cel_n,
    output logic                       mem_we_n,
    output logic                       mem_oe_n,
    output logic [2*LANE_W-1:0]        mem_dq_out,
    output logic [1:0]                 mem_dq_oe,
    input  logic [2*LANE_W-1:0]        mem_dq_in
);

    localparam int DATA_W   = LANE_COUNT * LANE_W;
    localparam int WP_CYC   = max3(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DS_NS, CLK_NS), 1);
    localparam int WC_CYC   = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int HOLD_CYC = max3(ns_to_cyc(T_WR_NS, CLK_NS), WC_CYC - WP_CYC, 1);
    localparam int RDW_CYC  = max3(ns_to_cyc(T_ACC_NS, CLK_NS) - 1,
                                   ns_to_cyc(T_OE_NS, CLK_NS),
                                   max3(ns_to_cyc(T_RC_NS, CLK_NS) - 1, 1, 1));
    localparam int CNT_MAX  = max3(WP_CYC, HOLD_CYC, RDW_CYC);
    localparam int CNT_W    = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             accept;
    logic             capture;
    logic [1:0]       lane_sel;
    logic [ADDR_W-1:0] addr_q;

    sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_seq_fsm #(
        .CNT_W    (CNT_W),
        .WP_CYC   (WP_CYC),
        .HOLD_CYC (HOLD_CYC),
        .RDW_CYC  (RDW_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_bmask   (req_bmask),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .accept      (accept),
        .capture     (capture),
        .lane_sel    (lane_sel),
        .ceu_n       (mem_ceu_n),
        .cel_n       (mem_cel_n),
        .we_n        (mem_we_n),
        .oe_n        (mem_oe_n),
        .lane_drive  (mem_dq_oe),
        .done        (done),
        .err         (done_err)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
        end
    end

    assign mem_addr = addr_q;

    // Lane 0 is bits 7:0 (lower enable), lane 1 is bits 15:8 (upper enable).
    for (genvar g = 0; g < LANE_COUNT; g++) begin : g_lane
        sram_lane_path #(.LANE_W(LANE_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .latch    (accept),
            .wdata_in (req_wdata[g*LANE_W +: LANE_W]),
            .capture  (capture),
            .lane_sel (lane_sel[g]),
            .dq_in    (mem_dq_in[g*LANE_W +: LANE_W]),
            .dq_out   (mem_dq_out[g*LANE_W +: LANE_W]),
            .rd_lane  (rd_data[g*LANE_W +: LANE_W])
        );
    end

    logic unused_ok;
    assign unused_ok = &{1'b0, DATA_W[0]};

endmodule

// File: rtl/sram_bytelane_ctrl_chk.sv
module sram_bytelane_ctrl_chk #(
    parameter int ADDR_W = 17,
    parameter int MIN_WP = 6,
    parameter int MIN_WC = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_ceu_n,
    input logic              mem_cel_n,
    input logic [1:0]        mem_dq_oe,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              done,
    input logic              done_err
);

    logic [15:0] low_run;
    logic [15:0] since_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run    <= '0;
            since_fall <= 16'hFFFF;
        end else begin
            if (!mem_we_n) begin
                if (low_run != 16'hFFFF) low_run <= low_run + 1'b1;
            end else begin
                low_run <= '0;
            end
            if (!mem_we_n && (low_run == '0)) begin
                since_fall <= 16'd1;
            end else if (since_fall != 16'hFFFF) begin
                since_fall <= since_fall + 1'b1;
            end
        end
    end

    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    p_turnaround_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> ($past(mem_dq_oe) == 2'b00));

    p_no_contention_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe != 2'b00) |-> mem_oe_n);

    p_write_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ceu_n || !mem_cel_n));

    p_drive_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_dq_oe == {!mem_ceu_n, !mem_cel_n}));

    p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_addr));

    p_pulse_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (low_run >= 16'(MIN_WP)));

    p_end_together_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_ceu_n && mem_cel_n));

    p_cycle_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> (since_fall >= 16'(MIN_WC)));

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_err |-> (done && mem_ceu_n && mem_cel_n && mem_we_n && mem_oe_n));

endmodule

bind sram_bytelane_ctrl sram_bytelane_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .MIN_WP (WP_CYC),
    .MIN_WC (WC_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_ceu_n (mem_ceu_n),
    .mem_cel_n (mem_cel_n),
    .mem_dq_oe (mem_dq_oe),
    .mem_addr  (mem_addr),
    .done      (done),
    .done_err  (done_err)
);

// File: tb/sram_bytelane_ctrl_test.sv
`timescale 1ns/1ps
module sram_bytelane_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_bmask = '0;
    logic        done, done_err;
    logic [15:0] rd_data;
    logic [16:0] mem_addr;
    logic        mem_ceu_n, mem_cel_n, mem_we_n, mem_oe_n;
    logic [15:0] mem_dq_out;
    logic [1:0]  mem_dq_oe;
    logic [15:0] mem_dq_in;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [15:0] ram    [0:255];
    logic [15:0] shadow [0:255];

    always #2 clk = ~clk;

    sram_bytelane_ctrl uut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_write (req_write), .req_addr (req_addr),
        .req_wdata (req_wdata), .req_bmask (req_bmask),
        .done (done), .done_err (done_err), .rd_data (rd_data),
        .mem_addr (mem_addr), .mem_ceu_n (mem_ceu_n), .mem_cel_n (mem_cel_n),
        .mem_we_n (mem_we_n), .mem_oe_n (mem_oe_n),
        .mem_dq_out (mem_dq_out), .mem_dq_oe (mem_dq_oe), .mem_dq_in (mem_dq_in)
    );

    // Simple RAM model: returns a fixed pattern whenever output enable is high.
    assign mem_dq_in = mem_oe_n ? 16'hA5A5 : ram[mem_addr[7:0]];

    always @(posedge clk) begin
        if (rst_n && !mem_we_n) begin
            if (!mem_ceu_n && mem_dq_oe[1]) ram[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
            if (!mem_cel_n && mem_dq_oe[0]) ram[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
        end
    end

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk(mem_ceu_n && mem_cel_n, "R1 enables idle", {mem_ceu_n, mem_cel_n}, 2'b11);
        chk(mem_we_n && mem_oe_n, "R1 strobes idle", {mem_we_n, mem_oe_n}, 2'b11);
        chk(mem_dq_oe == 2'b00, "R1 bus released", mem_dq_oe, 2'b00);
        chk(!done && !done_err, "R1 done low", {done, done_err}, 2'b00);
    endtask

    task automatic t_write(input logic [16:0] a, input logic [15:0] d, input logic [1:0] m, input bit intrude);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_bmask = m;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~d; req_bmask = ~m;
        for (int i = 1; i <= 8; i++) begin
            chk(mem_addr == a, "R5 address held", mem_addr, a);
            if (i <= 6) begin
                chk(!mem_we_n, "R2 strobe low", mem_we_n, 1'b0);
                chk(mem_oe_n, "R7 oe high in write", mem_oe_n, 1'b1);
                chk({mem_ceu_n, mem_cel_n} == ~m, "R3 lane enables", {mem_ceu_n, mem_cel_n}, ~m);
                chk(mem_dq_oe == m, "R4 lanes driven", mem_dq_oe, m);
                chk((mem_dq_out & {{8{m[1]}}, {8{m[0]}}}) == (d & {{8{m[1]}}, {8{m[0]}}}),
                    "R4 write data", mem_dq_out, d);
                chk(!done, "R2 no early done", done, 1'b0);
            end else if (i == 7) begin
                chk(mem_we_n && mem_ceu_n && mem_cel_n, "R8 end together",
                    {mem_we_n, mem_ceu_n, mem_cel_n}, 3'b111);
                chk(mem_dq_oe == m, "R4 data hold", mem_dq_oe, m);
                chk(!done, "R2 no early done", done, 1'b0);
            end else begin
                chk(done, "R2 write done", done, 1'b1);
                chk(!done_err, "R11 no error", done_err, 1'b0);
                chk(mem_dq_oe == 2'b00, "R4 bus released", mem_dq_oe, 2'b00);
            end
            if (intrude && i == 3) begin
                req_valid = 1'b1; req_write = 1'b0; req_addr = a ^ 17'h55; req_bmask = 2'b01;
            end else begin
                req_valid = 1'b0;
            end
            if (i < 8) @(negedge clk);
        end
        if (m[1]) shadow[a[7:0]][15:8] = d[15:8];
        if (m[0]) shadow[a[7:0]][7:0]  = d[7:0];
        @(negedge clk);
        chk(!done, "R2 done one cycle", done, 1'b0);
        if (intrude) begin
            for (int k = 0; k < 10; k++) begin
                chk(!done && mem_oe_n && mem_ceu_n && mem_cel_n, "R10 intruding request ignored",
                    {done, mem_oe_n, mem_ceu_n, mem_cel_n}, 4'b0111);
                @(negedge clk);
            end
        end
    endtask

    task automatic t_read(input logic [16:0] a, input logic [1:0] m);
        logic [15:0] exp;
        exp = shadow[a[7:0]] & {{8{m[1]}}, {8{m[0]}}};
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_bmask = m;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; req_bmask = ~m;
        for (int i = 1; i <= 8; i++) begin
            chk(mem_addr == a, "R5 address held", mem_addr, a);
            chk(mem_we_n, "R7 no strobe in read", mem_we_n, 1'b1);
            if (i == 1) begin
                chk(mem_oe_n, "R6 setup oe high", mem_oe_n, 1'b1);
                chk({mem_ceu_n, mem_cel_n} == ~m, "R3 read enables", {mem_ceu_n, mem_cel_n}, ~m);
                chk(mem_dq_oe == 2'b00, "R7 bus released before oe", mem_dq_oe, 2'b00);
            end else if (i <= 7) begin
                chk(!mem_oe_n, "R2 oe low", mem_oe_n, 1'b0);
                chk({mem_ceu_n, mem_cel_n} == ~m, "R3 read enables", {mem_ceu_n, mem_cel_n}, ~m);
                chk(!done, "R2 no early done", done, 1'b0);
            end else begin
                chk(done, "R2 read done", done, 1'b1);
                chk(!done_err, "R11 no error", done_err, 1'b0);
                chk(mem_oe_n, "R6 oe released", mem_oe_n, 1'b1);
                chk(rd_data == exp, "R6 read data", rd_data, exp);
            end
            if (i < 8) @(negedge clk);
        end
        @(negedge clk);
        chk(!done, "R2 done one cycle", done, 1'b0);
    endtask

    task automatic t_reject();
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00042; req_bmask = 2'b00;
        @(negedge clk);
        req_valid = 1'b0;
        chk(done && done_err, "R9 rejected done", {done, done_err}, 2'b11);
        chk(mem_we_n && mem_ceu_n && mem_cel_n && mem_oe_n, "R9 no RAM activity",
            {mem_we_n, mem_ceu_n, mem_cel_n, mem_oe_n}, 4'b1111);
        @(negedge clk);
        chk(!done && !done_err, "R9 single pulse", {done, done_err}, 2'b00);
        chk(mem_we_n && mem_ceu_n && mem_cel_n, "R9 still quiet",
            {mem_we_n, mem_ceu_n, mem_cel_n}, 3'b111);
    endtask

    initial begin
        for (int k = 0; k < 256; k++) begin
            ram[k] = 16'h0000;
            shadow[k] = 16'h0000;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_write(17'h00010, 16'h1234, 2'b11, 1'b0);
        t_read (17'h00010, 2'b11);
        t_write(17'h00010, 16'hAB99, 2'b10, 1'b0);
        t_read (17'h00010, 2'b11);
        t_write(17'h00010, 16'h77CD, 2'b01, 1'b0);
        t_read (17'h00010, 2'b01);
        t_read (17'h00010, 2'b10);
        t_write(17'h1FFFF, 16'hBEEF, 2'b11, 1'b0);
        t_read (17'h1FFFF, 2'b11);
        t_write(17'h00000, 16'h0F0F, 2'b11, 1'b1);
        t_read (17'h00000, 2'b11);
        t_reject();
        t_read (17'h00010, 2'b11);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        wait (cyc >= 20000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired: actual %0d expected below %0d", cyc, 20000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule